// File: doc/BRIEF.md
# UART FIFO Control Stage

This block holds the transmit and receive byte queues of a 16550-class serial port, together with the control register that governs them. The bus side writes the control byte at register offset 2. That offset is shared with the interrupt identification register, which lives outside this block, so the control byte has no read path. The bus pushes transmit bytes and pops received bytes. The serial shift logic pops transmit bytes and pushes received bytes.

Queue mode is off after reset. In that state each direction holds a single byte, like a plain holding register. Writing a control byte with bit 0 set turns on queue mode, and each direction then holds up to `DEPTH` bytes. Writing a control byte with bit 0 clear turns queue mode off and empties both queues. Two flush bits act for one cycle only and never stay set. A receive threshold flag reports when the receive occupancy reaches the programmed level.

Back-pressure rules:
- The transmit push port accepts a byte only in a cycle where `tx_in_valid` and `tx_in_ready` are both high.
- Both pop ports hand over a byte in a cycle where valid and ready are both high.
- The receive push port comes from shift logic that cannot stall, so it has no ready signal. A byte pushed while that queue is full is lost.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both occupancy counts are 0, `rx_trig` and `rx_overrun` are 0, queue mode is off, and the receive threshold is 1 byte.
- R2: With queue mode on, each queue accepts exactly `DEPTH` (16) bytes. After that, `tx_in_ready` is low and the count stays at 16.
- R3: With queue mode off, each direction holds at most one byte. A second transmit push is refused.
- R4: A control write with bit 0 = 0 empties both queues in the next cycle and turns queue mode off.
- R5: In a control write with bit 0 = 0, bits 1, 2 and 7:6 have no effect. In particular, the threshold keeps its old value.
- R6: A control write with bits 0 and 1 set empties only the receive queue and clears `rx_overrun`. The transmit queue keeps its contents.
- R7: A control write with bits 0 and 2 set empties only the transmit queue. The receive queue keeps its contents.
- R8: The flush bits act once. A later control write with bit 0 set and bits 1 and 2 clear empties nothing.
- R9: Control bits 7:6 select the receive threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8, 11 selects 14. `rx_trig` is high while `rx_count` is at or above the threshold, in either mode.
- R10: A receive push while the receive queue is full drops the byte and sets `rx_overrun`. The flag stays set until the receive queue is flushed.
- R11: A pop from an empty queue changes nothing. The count stays 0 and the data output keeps showing the last byte popped.
- R12: Writes at any offset other than 2 leave the mode, the threshold and the queues unchanged.
- R13: Bytes leave each queue in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_addr | input | 3 | Register offset; the control byte sits at 2 |
| ctl_wdata | input | 8 | Write data |
| tx_in_valid | input | 1 | Bus offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 8 | Transmit byte from the bus |
| tx_out_valid | output | 1 | Transmit byte available to the shifter |
| tx_out_ready | input | 1 | Shifter takes the byte |
| tx_out_data | output | 8 | Head of the transmit queue, or the last byte popped when empty |
| rx_in_valid | input | 1 | Shifter delivers a received byte (no stall) |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Received byte available to the bus |
| rx_out_ready | input | 1 | Bus takes the byte |
| rx_out_data | output | 8 | Head of the receive queue, or the last byte popped when empty |
| tx_count | output | 5 | Transmit occupancy |
| rx_count | output | 5 | Receive occupancy |
| rx_trig | output | 1 | Receive occupancy at or above the threshold |
| rx_overrun | output | 1 | A received byte was dropped |

## Verification
The hardest states to reach are where one control write must act on one queue and not the other. One case is a receive flush while transmit bytes wait. Another is a later enable write that must not repeat an earlier flush. Another is a write with bit 0 clear whose threshold field must be ignored. The vector table reaches these states by first loading both queues to known, different counts. It then issues each control byte and reads both counts and the threshold flag. The full-queue overrun and the empty-queue pop come from directed sequences. Those sequences fill the receive queue to 16 bytes, push once more, and drain it one byte past empty.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned FCR_OFFS = 2;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic logic [4:0] trig_bytes(trig_sel_e sel);
    case (sel)
      TRIG_1:  trig_bytes = 5'd1;
      TRIG_4:  trig_bytes = 5'd4;
      TRIG_8:  trig_bytes = 5'd8;
      default: trig_bytes = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
  import uart_fifo_pkg::*;
#(
  parameter int unsigned AW   = 3,
  parameter int unsigned OFFS = FCR_OFFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          fifo_en,
  output trig_sel_e     trig_sel,
  output logic          tx_flush,
  output logic          rx_flush
);
  logic hit;
  assign hit = we && (addr == AW'(OFFS));

  // Flush strobes exist only during the write cycle itself.
  always_comb begin
    tx_flush = 1'b0;
    rx_flush = 1'b0;
    if (hit) begin
      if (wdata[0]) begin
        rx_flush = wdata[1];
        tx_flush = wdata[2];
      end else begin
        rx_flush = 1'b1;
        tx_flush = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_sel <= TRIG_1;
    end else if (hit) begin
      fifo_en <= wdata[0];
      if (wdata[0]) trig_sel <= trig_sel_e'(wdata[7:6]);
    end
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [DW-1:0] last;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap       = single ? CW'(1) : CW'(DEPTH);
  assign in_ready  = (count < cap);
  assign out_valid = (count != '0);
  assign out_data  = out_valid ? mem[rp] : last;
  assign do_push   = in_valid && in_ready && !flush;
  assign do_pop    = out_ready && out_valid && !flush;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      last  <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop) begin
        rp   <= bump(rp);
        last <= mem[rp];
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [AW-1:0] ctl_addr,
  input  logic [7:0]    ctl_wdata,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [7:0]    tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_data,
  input  logic          rx_in_valid,
  input  logic [7:0]    rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [7:0]    rx_out_data,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          rx_trig,
  output logic          rx_overrun
);
  logic      fifo_en, tx_flush, rx_flush, rx_space;
  trig_sel_e trig_sel;

  fcr_decode #(.AW(AW), .OFFS(FCR_OFFS)) u_fcr (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .addr(ctl_addr), .wdata(ctl_wdata),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!fifo_en),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_count)
  );

  byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!fifo_en),
    .in_valid(rx_in_valid), .in_ready(rx_space), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_count)
  );

  assign rx_trig = ({{(CW > 5 ? CW - 5 : 0){1'b0}}, trig_bytes(trig_sel)} <= rx_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rx_overrun <= 1'b0;
    else if (rx_flush)                  rx_overrun <= 1'b0;
    else if (rx_in_valid && !rx_space)  rx_overrun <= 1'b1;
  end
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [AW-1:0] ctl_addr,
  input logic [7:0]    ctl_wdata,
  input logic          fifo_en,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_in_valid,
  input logic          rx_out_ready,
  input logic [7:0]    rx_out_data,
  input logic          rx_trig,
  input logic          rx_overrun
);
  logic fcr_hit;
  assign fcr_hit = ctl_we && (ctl_addr == AW'(2));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (tx_count <= CW'(1)) && (rx_count <= CW'(1)));

  a_r4_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_hit && !ctl_wdata[0]) |=> (tx_count == '0) && (rx_count == '0) && !fifo_en);

  a_r6_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_hit && ctl_wdata[0] && ctl_wdata[1]) |=> (rx_count == '0) && !rx_overrun);

  a_r7_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_hit && ctl_wdata[0] && ctl_wdata[2]) |=> (tx_count == '0));

  a_r9_trig_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> (rx_count != '0));

  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_in_valid));

  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && (rx_count == '0) && !rx_in_valid) |=> $stable(rx_out_data) && (rx_count == '0));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
  .fifo_en(fifo_en), .tx_count(tx_count), .rx_count(rx_count), .rx_in_valid(rx_in_valid),
  .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data), .rx_trig(rx_trig),
  .rx_overrun(rx_overrun)
);

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  // op codes for the vector table
  localparam logic [3:0] OP_WR = 0, OP_WRO = 1, OP_TXPUSH = 2, OP_RXPUSH = 3,
                         OP_TXPOP = 4, OP_RXPOP = 5, OP_CHKTX = 6, OP_CHKRX = 7,
                         OP_CHKTRIG = 8, OP_CHKOVR = 9;

  // {op, requirement number, argument, expected}
  localparam int NV = 40;
  localparam logic [23:0] VEC [NV] = '{
    {OP_CHKTX,   4'd1,  8'h00, 8'd0},   // R1
    {OP_CHKRX,   4'd1,  8'h00, 8'd0},   // R1
    {OP_CHKTRIG, 4'd1,  8'h00, 8'd0},   // R1
    {OP_TXPUSH,  4'd3,  8'hA1, 8'd0},
    {OP_TXPUSH,  4'd3,  8'hA2, 8'd0},   // refused: single slot
    {OP_CHKTX,   4'd3,  8'h00, 8'd1},   // R3
    {OP_TXPOP,   4'd13, 8'h00, 8'hA1},  // R13
    {OP_WR,      4'd5,  8'hC0, 8'd0},   // bit0=0: threshold field ignored
    {OP_RXPUSH,  4'd5,  8'h55, 8'd0},
    {OP_CHKTRIG, 4'd5,  8'h00, 8'd1},   // R5 threshold still 1
    {OP_CHKRX,   4'd5,  8'h00, 8'd1},
    {OP_WR,      4'd9,  8'h41, 8'd0},   // enable, threshold 4
    {OP_CHKTRIG, 4'd9,  8'h00, 8'd0},   // R9
    {OP_RXPUSH,  4'd9,  8'h56, 8'd0},
    {OP_RXPUSH,  4'd9,  8'h57, 8'd0},
    {OP_CHKTRIG, 4'd9,  8'h00, 8'd0},   // 3 < 4
    {OP_RXPUSH,  4'd9,  8'h58, 8'd0},
    {OP_CHKTRIG, 4'd9,  8'h00, 8'd1},   // 4 >= 4
    {OP_RXPOP,   4'd13, 8'h00, 8'h55},  // R13
    {OP_TXPUSH,  4'd6,  8'h11, 8'd0},
    {OP_TXPUSH,  4'd6,  8'h22, 8'd0},
    {OP_WR,      4'd6,  8'h03, 8'd0},   // receive flush
    {OP_CHKRX,   4'd6,  8'h00, 8'd0},   // R6
    {OP_CHKTX,   4'd6,  8'h00, 8'd2},   // R6 transmit kept
    {OP_WR,      4'd8,  8'h01, 8'd0},
    {OP_CHKTX,   4'd8,  8'h00, 8'd2},   // R8
    {OP_RXPUSH,  4'd8,  8'h66, 8'd0},
    {OP_CHKRX,   4'd8,  8'h00, 8'd1},   // R8
    {OP_WR,      4'd7,  8'h05, 8'd0},   // transmit flush
    {OP_CHKTX,   4'd7,  8'h00, 8'd0},   // R7
    {OP_CHKRX,   4'd7,  8'h00, 8'd1},   // R7 receive kept
    {OP_WRO,     4'd12, 8'h00, 8'd0},   // other offset
    {OP_RXPUSH,  4'd12, 8'h67, 8'd0},
    {OP_CHKRX,   4'd12, 8'h00, 8'd2},   // R12 still queue mode
    {OP_WR,      4'd4,  8'h00, 8'd0},   // leave queue mode
    {OP_CHKRX,   4'd4,  8'h00, 8'd0},   // R4
    {OP_CHKTX,   4'd4,  8'h00, 8'd0},   // R4
    {OP_RXPUSH,  4'd4,  8'h70, 8'd0},
    {OP_RXPUSH,  4'd4,  8'h71, 8'd0},   // dropped: single slot
    {OP_CHKRX,   4'd4,  8'h00, 8'd1}    // R4 back to one byte
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_addr = '0;
  logic [7:0] ctl_wdata = '0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       tx_in_ready, tx_out_valid, rx_out_valid, rx_trig, rx_overrun;
  logic [7:0] tx_out_data, rx_out_data;
  logic [4:0] tx_count, rx_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_count(tx_count), .rx_count(rx_count), .rx_trig(rx_trig), .rx_overrun(rx_overrun)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(int req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic rxpush(logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d;
    step();
    rx_in_valid = 1'b0;
  endtask

  task automatic txpush(logic [7:0] d);
    tx_in_valid = 1'b1; tx_in_data = d;
    step();
    tx_in_valid = 1'b0;
  endtask

  task automatic rxpop(int req, logic [7:0] exp);
    check(req, rx_out_data, exp, "rx_out_data");
    rx_out_ready = 1'b1;
    step();
    rx_out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      int req;
      logic [7:0] arg, exp;
      {op, arg, exp} = {VEC[i][23:20], VEC[i][15:0]};
      req = int'(VEC[i][19:16]);
      case (op)
        OP_WR:      wr(3'd2, arg);
        OP_WRO:     wr(3'd3, arg);
        OP_TXPUSH:  txpush(arg);
        OP_RXPUSH:  rxpush(arg);
        OP_TXPOP: begin
          check(req, tx_out_data, exp, "tx_out_data");
          tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
        end
        OP_RXPOP:   rxpop(req, exp);
        OP_CHKTX:   check(req, tx_count, exp, "tx_count");
        OP_CHKRX:   check(req, rx_count, exp, "rx_count");
        OP_CHKTRIG: check(req, rx_trig, exp, "rx_trig");
        default:    check(req, rx_overrun, exp, "rx_overrun");
      endcase
    end

    // R11: pop the held byte, then pop on empty
    rxpop(11, 8'h70);
    rxpop(11, 8'h70);
    check(11, rx_count, 0, "rx_count after empty pop (R11)");
    check(11, rx_out_data, 8'h70, "rx_out_data held (R11)");

    // R9 threshold 14, R10 overrun, R13 order over a full queue
    wr(3'd2, 8'hC7);
    for (int k = 0; k < DEPTH; k++) begin
      rxpush(8'h80 + 8'(k));
      if (k == 12) check(9, rx_trig, 0, "rx_trig at 13 (R9)");
      if (k == 13) check(9, rx_trig, 1, "rx_trig at 14 (R9)");
    end
    check(2, rx_count, DEPTH, "rx_count full (R2)");
    check(10, rx_overrun, 0, "rx_overrun before extra push (R10)");
    rxpush(8'hEE);
    check(10, rx_overrun, 1, "rx_overrun (R10)");
    check(10, rx_count, DEPTH, "rx_count after drop (R10)");
    for (int k = 0; k < DEPTH; k++) rxpop(13, 8'h80 + 8'(k));
    check(10, rx_overrun, 1, "rx_overrun sticky (R10)");
    wr(3'd2, 8'h03);
    check(6, rx_overrun, 0, "rx_overrun cleared by flush (R6)");

    // R2 transmit capacity
    for (int k = 0; k < DEPTH; k++) txpush(8'(k));
    check(2, tx_in_ready, 0, "tx_in_ready when full (R2)");
    txpush(8'hFF);
    check(2, tx_count, DEPTH, "tx_count full (R2)");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule